// File: doc/BRIEF.md
# Instruction Predecode Unit

This block sits in the line-fill path between memory and the instruction cache. For each 32-bit instruction that arrives with its fill address, it works out a 6-bit predecode tag. The tag gives the instruction's class and the execution resource it needs. For direct branches it also computes the branch target and marks it as valid. The instruction, the tag and the target leave the block together, so the cache can store them side by side, and the later decode and issue stages do not have to repeat this work.

The block accepts one instruction per cycle through a valid/ready handshake and presents it one cycle later through a single output register. Order is preserved. Backpressure from the cache side stalls the input directly, with no extra buffering.

The opcode is bits 31..26 of the instruction, and the branch offset is bits 15..0. The tag layout is bit 5 = target valid, bits 4..2 = resource, bits 1..0 = class. Class codes are ALU=00, memory=01, branch=10, other=11. Resource codes are integer=000, load/store=001, FP=010, branch unit=011, multiply/divide=100, illegal=111.

Top module: `pdec_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, `out_valid` is 0. In that same cycle `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, the outputs hold their values on the next cycle.
- R3: An instruction accepted on a clock edge (`in_valid && in_ready`) appears unchanged on `out_instr` with `out_valid` high after that edge. Outputs leave in acceptance order, and one instruction can be accepted every cycle.
- R4: The class field (tag bits 1..0) is as follows. Opcodes 0x00-0x0F give ALU (00). Opcodes 0x10-0x1B give memory (01). Opcodes 0x20-0x2B give branch (10). All other opcodes give other (11).
- R5: The resource field (tag bits 4..2) is as follows. Opcodes 0x00-0x07 and 0x3C-0x3F give integer (000). Opcodes 0x08-0x0B give multiply/divide (100). Opcodes 0x0C-0x0F give FP (010). Opcodes 0x10-0x1B give load/store (001). Opcodes 0x20-0x2B give branch unit (011).
- R6: Opcodes 0x20-0x29 are direct branches. For these, tag bit 5 is 1, and `out_target` equals the fill address plus the sign-extended 16-bit offset times 4, modulo 2^ADDR_W.
- R7: For every other opcode, including the register jumps 0x2A and 0x2B, tag bit 5 is 0 and `out_target` is 0.
- R8: Undefined opcodes are 0x1C-0x1F and 0x2C-0x3B. Each is tagged class other (11) with resource illegal (111).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fill word present |
| in_ready | output | 1 | Block can take a fill word this cycle |
| in_addr | input | ADDR_W | Byte address of the fill word |
| in_instr | input | 32 | Instruction word from memory |
| out_valid | output | 1 | Predecoded word present |
| out_ready | input | 1 | Cache side takes the word this cycle |
| out_instr | output | 32 | Instruction passed through unchanged |
| out_tag | output | 6 | Predecode tag {target valid, resource, class} |
| out_target | output | ADDR_W | Precomputed direct-branch target, else 0 |

## Verification
The handshake assertions assume that `rst` is high on the first clock edge, and that `in_instr` is a known value whenever `in_valid` is high. The bench holds reset for several cycles and always drives fully defined words. The assertions make no assumption about input stability under backpressure, so the stimulus changes the input word freely while `in_ready` is low, and it toggles `out_ready` at random. Opcodes come from a full sweep of all 64 codes, followed by uniform random words. Directed offsets at the sign boundaries and addresses near the top of the address space exercise target wraparound.

// File: rtl/pdec_pkg.sv
`timescale 1ns/1ps
package pdec_pkg;

  localparam int OPC_W  = 6;
  localparam int TAG_W  = 6;
  localparam int INSN_W = 32;

  typedef enum logic [1:0] {
    CLS_ALU   = 2'b00,
    CLS_MEM   = 2'b01,
    CLS_BR    = 2'b10,
    CLS_OTHER = 2'b11
  } insn_cls_e;

  typedef enum logic [2:0] {
    RES_INT     = 3'b000,
    RES_LSU     = 3'b001,
    RES_FP      = 3'b010,
    RES_BRU     = 3'b011,
    RES_MULDIV  = 3'b100,
    RES_ILLEGAL = 3'b111
  } exec_res_e;

  typedef struct packed {
    logic      tgt_ok;
    exec_res_e res;
    insn_cls_e cls;
  } pd_tag_t;

  // Opcode groups of four, selected by opcode bits 5..2.
  function automatic insn_cls_e opc_class(input logic [OPC_W-1:0] opc);
    insn_cls_e c;
    case (opc[5:2])
      4'h0, 4'h1, 4'h2, 4'h3: c = CLS_ALU;
      4'h4, 4'h5, 4'h6:       c = CLS_MEM;
      4'h8, 4'h9, 4'hA:       c = CLS_BR;
      default:                c = CLS_OTHER;
    endcase
    return c;
  endfunction

  function automatic exec_res_e opc_resource(input logic [OPC_W-1:0] opc);
    exec_res_e r;
    case (opc[5:2])
      4'h0, 4'h1:       r = RES_INT;
      4'h2:             r = RES_MULDIV;
      4'h3:             r = RES_FP;
      4'h4, 4'h5, 4'h6: r = RES_LSU;
      4'h8, 4'h9, 4'hA: r = RES_BRU;
      4'hF:             r = RES_INT;
      default:          r = RES_ILLEGAL;
    endcase
    return r;
  endfunction

  // Direct branches: groups 8 and 9 in full, and the first half of group A.
  function automatic logic opc_direct(input logic [OPC_W-1:0] opc);
    logic d;
    case (opc[5:2])
      4'h8, 4'h9: d = 1'b1;
      4'hA:       d = ~opc[1];
      default:    d = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pdec_classify.sv
`timescale 1ns/1ps
module pdec_classify
  import pdec_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output insn_cls_e        cls,
  output exec_res_e        res,
  output logic             direct
);

  always_comb begin
    cls    = opc_class(opc);
    res    = opc_resource(opc);
    direct = opc_direct(opc);
  end

endmodule

// File: rtl/pdec_target.sv
`timescale 1ns/1ps
module pdec_target #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [OFF_W-1:0]  offset,
  input  logic              direct,
  output logic [ADDR_W-1:0] target
);

  localparam int SH_W = OFF_W + 2;

  logic [ADDR_W-1:0] disp;
  logic [ADDR_W-1:0] sum;

  generate
    if (ADDR_W > SH_W) begin : g_sext
      localparam int PAD_W = ADDR_W - SH_W;
      assign disp = {{PAD_W{offset[OFF_W-1]}}, offset, 2'b00};
    end else begin : g_trunc
      logic [SH_W-1:0] shifted;
      assign shifted = {offset, 2'b00};
      assign disp    = shifted[ADDR_W-1:0];
    end
  endgenerate

  assign sum    = addr + disp;
  assign target = direct ? sum : '0;

endmodule

// File: rtl/pdec_stage.sv
`timescale 1ns/1ps
module pdec_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  logic         vld_q;
  logic [W-1:0] data_q;

  assign up_ready = ~vld_q | dn_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (up_ready) begin
      vld_q <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (up_ready && up_valid) begin
      data_q <= up_data;
    end
  end

  assign dn_valid = vld_q;
  assign dn_data  = data_q;

endmodule

// File: rtl/pdec_unit.sv
`timescale 1ns/1ps
module pdec_unit
  import pdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [31:0]       in_instr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_instr,
  output logic [5:0]        out_tag,
  output logic [ADDR_W-1:0] out_target
);

  localparam int PAY_W = INSN_W + TAG_W + ADDR_W;

  insn_cls_e         cls;
  exec_res_e         res;
  logic              direct;
  logic [ADDR_W-1:0] target;
  pd_tag_t           tag_d;
  logic [PAY_W-1:0]  pay_d;
  logic [PAY_W-1:0]  pay_q;

  // Named handshake events, observed by the bound checker.
  logic in_fire;
  logic out_fire;
  logic out_stall;

  pdec_classify u_cls (
    .opc    (in_instr[31:26]),
    .cls    (cls),
    .res    (res),
    .direct (direct)
  );

  pdec_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tgt (
    .addr   (in_addr),
    .offset (in_instr[OFF_W-1:0]),
    .direct (direct),
    .target (target)
  );

  always_comb begin
    tag_d.tgt_ok = direct;
    tag_d.res    = res;
    tag_d.cls    = cls;
  end

  assign pay_d = {in_instr, tag_d, target};

  pdec_stage #(.W(PAY_W)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (pay_d),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pay_q)
  );

  assign out_instr  = pay_q[PAY_W-1 -: INSN_W];
  assign out_tag    = pay_q[ADDR_W +: TAG_W];
  assign out_target = pay_q[ADDR_W-1:0];

  assign in_fire   = in_valid & in_ready;
  assign out_fire  = out_valid & out_ready;
  assign out_stall = out_valid & ~out_ready;

endmodule

// File: rtl/pdec_unit_chk.sv
`timescale 1ns/1ps
module pdec_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_fire,
  input logic              out_stall,
  input logic              out_valid,
  input logic [31:0]       in_instr,
  input logic [31:0]       out_instr,
  input logic [5:0]        out_tag,
  input logic [ADDR_W-1:0] out_target
);

  // R1: reset empties the output register
  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !out_valid);

  // R2: a stalled output keeps its contents
  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
    out_stall |=> out_valid && $stable(out_instr) && $stable(out_tag) && $stable(out_target));

  // R3: an accepted word is presented next cycle, unchanged
  assert_accept_pass_R3: assert property (@(posedge clk) disable iff (rst)
    in_fire |=> out_valid && out_instr == $past(in_instr));

  // R5: memory-class words always go to load/store
  assert_mem_lsu_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_tag[1:0] == 2'b01 |-> out_tag[4:2] == 3'b001);

  // R6: a valid target belongs only to a branch on the branch unit
  assert_tgt_branch_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_tag[5] |-> out_tag[1:0] == 2'b10 && out_tag[4:2] == 3'b011);

  // R7: no target flag means a zero target
  assert_no_tgt_zero_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_tag[5] |-> out_target == '0);

  // R8: an illegal resource is always class other, without a target
  assert_illegal_other_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_tag[4:2] == 3'b111 |-> out_tag[1:0] == 2'b11 && !out_tag[5]);

endmodule

bind pdec_unit pdec_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_fire    (in_fire),
  .out_stall  (out_stall),
  .out_valid  (out_valid),
  .in_instr   (in_instr),
  .out_instr  (out_instr),
  .out_tag    (out_tag),
  .out_target (out_target)
);

// File: tb/pdec_unit_bench.sv
`timescale 1ns/1ps
module pdec_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic [31:0] in_instr = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_instr;
  logic [5:0]  out_tag;
  logic [31:0] out_target;

  int checks = 0;
  int failures = 0;
  int accepts = 0;
  bit done = 1'b0;

  logic [63:0] q[$];
  bit          hold_pend = 1'b0;
  logic [69:0] hold_snap;

  always #2.5 clk = ~clk;

  pdec_unit u_pdec_unit (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_instr(in_instr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_instr(out_instr), .out_tag(out_tag), .out_target(out_target)
  );

  function automatic logic [1:0] e_cls(input logic [5:0] op);
    if (op <= 6'h0F) return 2'b00;
    if (op <= 6'h1B) return 2'b01;
    if (op >= 6'h20 && op <= 6'h2B) return 2'b10;
    return 2'b11;
  endfunction

  function automatic logic [2:0] e_res(input logic [5:0] op);
    if (op <= 6'h07) return 3'b000;
    if (op <= 6'h0B) return 3'b100;
    if (op <= 6'h0F) return 3'b010;
    if (op <= 6'h1B) return 3'b001;
    if (op >= 6'h20 && op <= 6'h2B) return 3'b011;
    if (op >= 6'h3C) return 3'b000;
    return 3'b111;
  endfunction

  function automatic bit e_direct(input logic [5:0] op);
    return op inside {[6'h20:6'h29]};
  endfunction

  function automatic logic [31:0] e_target(input logic [31:0] a, input logic [31:0] ins);
    int off;
    off = int'($signed(ins[15:0]));
    if (!e_direct(ins[31:26])) return 32'h0;
    return a + 32'(off * 4);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cycle(input logic v, input logic [31:0] a, input logic [31:0] ins, input logic r);
    logic [63:0] item;
    logic [5:0]  op;
    logic [5:0]  etag;
    @(negedge clk);
    in_valid = v; in_addr = a; in_instr = ins; out_ready = r;
    #1;
    check(in_ready == (!out_valid || out_ready), "R2", "in_ready", 64'(in_ready),
          64'(!out_valid || out_ready));
    if (hold_pend) begin
      check(out_valid && {out_instr, out_tag, out_target} == hold_snap, "R2", "stall hold",
            64'({out_instr, out_tag}), 64'(hold_snap[69:32]));
    end
    if (out_valid && out_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R3", "unexpected output", 64'(out_instr), 64'h0);
      end else begin
        item = q.pop_front();
        op   = item[31:26];
        etag = {e_direct(op), e_res(op), e_cls(op)};
        check(out_instr == item[31:0], "R3", "instr order", 64'(out_instr), 64'(item[31:0]));
        check(out_tag[1:0] == etag[1:0], "R4", "class", 64'(out_tag[1:0]), 64'(etag[1:0]));
        check(out_tag[4:2] == etag[4:2], "R5", "resource", 64'(out_tag[4:2]), 64'(etag[4:2]));
        check(out_tag[5] == etag[5], etag[5] ? "R6" : "R7", "tgt flag", 64'(out_tag[5]), 64'(etag[5]));
        check(out_target == e_target(item[63:32], item[31:0]), etag[5] ? "R6" : "R7",
              "target", 64'(out_target), 64'(e_target(item[63:32], item[31:0])));
        if (etag[4:2] == 3'b111)
          check(out_tag[1:0] == 2'b11, "R8", "illegal class", 64'(out_tag), 64'(etag));
      end
    end
    hold_pend = out_valid && !out_ready;
    hold_snap = {out_instr, out_tag, out_target};
    if (in_valid && in_ready) begin
      q.push_back({a, ins});
      accepts++;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && (q.size() != 0 || out_valid); i++) cycle(1'b0, 32'h0, 32'h0, 1'b1);
    check(q.size() == 0 && !out_valid, "R3", "drained", 64'(q.size()), 64'h0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'h0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'h1);

    // R3: full-rate sweep of all 64 opcodes, R4/R5/R8 per opcode
    accepts = 0;
    for (int op = 0; op < 64; op++)
      cycle(1'b1, 32'h1000 + 32'(op * 4), {6'(op), 10'h155, 16'h0010}, 1'b1);
    check(accepts == 64, "R3", "one per cycle", 64'(accepts), 64'd64);
    drain();

    // R6: offset sign boundaries and address wraparound
    cycle(1'b1, 32'h0000_4000, {6'h20, 10'h0, 16'h8000}, 1'b1);
    cycle(1'b1, 32'h0000_4000, {6'h28, 10'h0, 16'h7FFF}, 1'b1);
    cycle(1'b1, 32'hFFFF_FFFC, {6'h29, 10'h0, 16'h0001}, 1'b1);
    cycle(1'b1, 32'h0000_0000, {6'h25, 10'h0, 16'hFFFF}, 1'b1);
    // R7: register jumps carry no target
    cycle(1'b1, 32'h0000_8000, {6'h2A, 10'h0, 16'h0040}, 1'b1);
    cycle(1'b1, 32'h0000_8000, {6'h2B, 10'h0, 16'hFFF0}, 1'b1);
    // R2: long stall with the input changing underneath
    cycle(1'b1, 32'h0000_0100, {6'h21, 10'h3, 16'h0100}, 1'b0);
    for (int i = 0; i < 4; i++) cycle(1'b1, 32'(i * 8), 32'hDEAD_0000 + 32'(i), 1'b0);
    drain();

    // Random traffic with random backpressure
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++)
      cycle(($urandom % 4) != 0, $urandom & 32'hFFFF_FFFC, $urandom, ($urandom % 3) != 0);
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule